// File: doc/BRIEF.md
# RISC Instruction Decoder

This block is the combinational decode stage of a 32-bit load/store core with separate instruction and data memories and 32 general registers. It takes one instruction word and produces the register indices, the 4-bit condition, a 32-bit extended immediate and every control line the later stages need. These are the ALU operation, the operand select, the register and flag write enables, the memory read and write strobes, the conditional-move select, and the jump, call and return indicators.

One 6-bit opcode in bits [31:26] covers two word layouts, and bit 31 chooses between them. In the register layout, bits [25:21] hold the second source register, [20:16] the destination, [15:11] the first source and [10:7] a condition. In the immediate layout, bits [25:21] hold either a source register or, for jumps, a condition, and bits [15:0] hold the immediate. Register 0 reads as zero and is never written. Register 31 is the stack pointer, and calls and returns use it implicitly.

The decoder has no state. Pipeline registers, hazard logic, the register file and the memories are outside it.

Top module: `insn_decoder`

## Requirements
- R1: `rs_idx` is bits [15:11], `rd_idx` is bits [20:16], and `rt_idx` is bits [25:21] for every opcode other than jump, call and return. For a register-layout word, `cond` is bits [10:7].
- R2: For a defined opcode, `use_imm` equals bit 31. A register-layout word gives `imm_ext` = 0.
- R3: The arithmetic opcodes x00000..x00011 give `alu_op` 0..3 (add, subtract, add with carry, subtract with borrow). The logic opcodes x01000..x01101 give `alu_op` 8..13 (and, and-not, xor, xor-not, or, or-not).
- R4: Insert-low 000100 gives `alu_op` 4 and insert-high 000110 gives 5. Upper-half immediate insert 110100 gives 6, and its inverted-register variant 110101 gives 7.
- R5: `flag_we` is 1 only for the arithmetic, logic, insert-low and insert-high operations. It is 0 for immediate insert, memory, move and control transfer.
- R6: The 16-bit immediate is sign-extended for immediate arithmetic, direct jump, direct call and return. It is zero-extended for immediate logic, immediate insert, and immediate-address load and store.
- R7: Loads 010000 and 110000 assert `mem_rd` and write rd. Stores 010010 and 110010 assert `mem_wr` and write no register.
- R8: 010100 asserts `cmov`, gives `alu_op` 14 (pass) and writes rd.
- R9: Jumps 011100 (register target) and 111100 (immediate target) assert `jump`. `cond` is bits [24:21], where 1000 means always, and `rt_idx` is 0. No register, flag or memory write occurs.
- R10: Calls 011110 and 111110 assert `call` and `mem_wr`, with `rt_idx` = 31 and no register write.
- R11: Return 111000 asserts `ret` and `mem_rd`, writes register 31 (`dst_idx` = 31), reads `rt_idx` = 31 and uses `alu_op` 0.
- R12: A register-writing operation whose destination is 0 gives `reg_we` = 0 and `dst_idx` = 0. Its `flag_we` is unchanged.
- R13: An undefined opcode deasserts `reg_we`, `flag_we`, `mem_rd`, `mem_wr`, `cmov`, `jump`, `call` and `ret`, and gives `alu_op` 14 and `use_imm` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rs_idx | output | 5 | First source register |
| rt_idx | output | 5 | Second source / address register |
| rd_idx | output | 5 | Destination field as encoded |
| dst_idx | output | 5 | Register actually written (0 when none) |
| cond | output | 4 | Condition selector |
| imm_ext | output | 32 | Extended immediate |
| alu_op | output | 4 | ALU operation code |
| use_imm | output | 1 | Second operand is the immediate |
| reg_we | output | 1 | Register write enable |
| flag_we | output | 1 | Flag write enable |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| cmov | output | 1 | Conditional move select |
| jump | output | 1 | Conditional or unconditional jump |
| call | output | 1 | Subroutine call |
| ret | output | 1 | Subroutine return |

## Verification
The decoder holds no state, so any fault in it shows at the ports in the same evaluation as the word that triggers it, and the bench samples one step after each word is applied. A wrong opcode class appears as a misplaced strobe: a store that also writes a register, a jump that raises `flag_we`, or an undefined word that is not silent. A wrong extension or field slice appears as a bad `imm_ext`, `cond` or index value. The bench targets the cases where a field changes role, namely the rt field carrying a condition, register 31 implied by call and return, and destination 0.

// File: rtl/insn_decoder.sv
module insn_decoder #(
  parameter int XLEN = 32,
  parameter int RW   = 5,
  parameter int SP   = 31
) (
  input  logic [31:0]     instr,
  output logic [RW-1:0]   rs_idx,
  output logic [RW-1:0]   rt_idx,
  output logic [RW-1:0]   rd_idx,
  output logic [RW-1:0]   dst_idx,
  output logic [3:0]      cond,
  output logic [XLEN-1:0] imm_ext,
  output logic [3:0]      alu_op,
  output logic            use_imm,
  output logic            reg_we,
  output logic            flag_we,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            cmov,
  output logic            jump,
  output logic            call,
  output logic            ret
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_ADC = 4'd2, OP_SBB = 4'd3;
  localparam logic [3:0] OP_INSL = 4'd4, OP_INSH = 4'd5, OP_INSI = 4'd6, OP_INSIN = 4'd7;
  localparam logic [3:0] OP_PASS = 4'd14;
  localparam logic [RW-1:0] SP_IDX = RW'(SP);

  logic [5:0]  opc;
  logic        ifmt;
  logic [15:0] imm16;
  logic        valid, wr_rd, wr_sp, sext, zext, ctrl;

  assign opc    = instr[31:26];
  assign ifmt   = instr[31];
  assign imm16  = instr[15:0];
  assign rs_idx = instr[15:11];
  assign rd_idx = instr[20:16];

  always_comb begin
    valid   = 1'b0;
    wr_rd   = 1'b0;
    wr_sp   = 1'b0;
    sext    = 1'b0;
    zext    = 1'b0;
    ctrl    = 1'b0;
    alu_op  = OP_PASS;
    flag_we = 1'b0;
    mem_rd  = 1'b0;
    mem_wr  = 1'b0;
    cmov    = 1'b0;
    jump    = 1'b0;
    call    = 1'b0;
    ret     = 1'b0;
    unique casez (opc)
      6'b?000??: begin
        valid = 1'b1; wr_rd = 1'b1; flag_we = 1'b1; sext = ifmt;
        alu_op = {2'b00, opc[1:0]};
      end
      6'b?01000, 6'b?01001, 6'b?01010, 6'b?01011, 6'b?01100, 6'b?01101: begin
        valid = 1'b1; wr_rd = 1'b1; flag_we = 1'b1; zext = ifmt;
        alu_op = {1'b1, opc[2:0]};
      end
      6'b000100: begin valid = 1'b1; wr_rd = 1'b1; flag_we = 1'b1; alu_op = OP_INSL; end
      6'b000110: begin valid = 1'b1; wr_rd = 1'b1; flag_we = 1'b1; alu_op = OP_INSH; end
      6'b110100: begin valid = 1'b1; wr_rd = 1'b1; zext = 1'b1; alu_op = OP_INSI; end
      6'b110101: begin valid = 1'b1; wr_rd = 1'b1; zext = 1'b1; alu_op = OP_INSIN; end
      6'b?10000: begin valid = 1'b1; wr_rd = 1'b1; mem_rd = 1'b1; zext = ifmt; end
      6'b?10010: begin valid = 1'b1; mem_wr = 1'b1; zext = ifmt; end
      6'b010100: begin valid = 1'b1; wr_rd = 1'b1; cmov = 1'b1; end
      6'b?11100: begin valid = 1'b1; jump = 1'b1; ctrl = 1'b1; sext = ifmt; end
      6'b?11110: begin valid = 1'b1; call = 1'b1; mem_wr = 1'b1; ctrl = 1'b1; sext = ifmt; end
      6'b111000: begin
        valid = 1'b1; ret = 1'b1; mem_rd = 1'b1; wr_sp = 1'b1; ctrl = 1'b1; sext = 1'b1;
        alu_op = OP_ADD;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (jump)              rt_idx = '0;
    else if (call || ret)  rt_idx = SP_IDX;
    else                   rt_idx = instr[25:21];
  end

  assign cond = jump ? instr[24:21] : (ifmt ? 4'd0 : instr[10:7]);

  assign use_imm = valid & ifmt;

  always_comb begin
    if (sext)      imm_ext = {{(XLEN-16){imm16[15]}}, imm16};
    else if (zext) imm_ext = {{(XLEN-16){1'b0}}, imm16};
    else           imm_ext = '0;
  end

  logic [RW-1:0] dst_raw;
  assign dst_raw = wr_sp ? SP_IDX : rd_idx;
  assign reg_we  = (wr_rd | wr_sp) && (dst_raw != '0);
  assign dst_idx = reg_we ? dst_raw : '0;

  always_comb begin
    if (!$isunknown(instr)) begin
      assert_mem_excl_R7: assert (!(mem_rd && mem_wr));
      assert_zero_dst_R12: assert (!reg_we || dst_idx != '0);
      assert_ctrl_quiet_R9: assert (!ctrl || (!flag_we && !(reg_we && !ret)));
      assert_call_store_R10: assert (!call || (mem_wr && rt_idx == SP_IDX));
      assert_ret_sp_R11: assert (!ret || (mem_rd && dst_idx == SP_IDX));
      assert_undef_silent_R13: assert (valid || !(reg_we || flag_we || mem_rd || mem_wr || use_imm));
      assert_flag_alu_R5: assert (!flag_we || alu_op < OP_INSI || (alu_op >= 4'd8 && alu_op <= 4'd13));
    end
  end
endmodule

// File: tb/tb_insn_decoder.sv
module tb_insn_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instr;
  logic [4:0]  rs_idx, rt_idx, rd_idx, dst_idx;
  logic [3:0]  cond, alu_op;
  logic [31:0] imm_ext;
  logic use_imm, reg_we, flag_we, mem_rd, mem_wr, cmov, jump, call, ret;

  insn_decoder dut (
    .instr(instr), .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx), .dst_idx(dst_idx),
    .cond(cond), .imm_ext(imm_ext), .alu_op(alu_op), .use_imm(use_imm), .reg_we(reg_we),
    .flag_we(flag_we), .mem_rd(mem_rd), .mem_wr(mem_wr), .cmov(cmov), .jump(jump),
    .call(call), .ret(ret)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  function automatic logic [31:0] rw(input logic [5:0] op, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [4:0] rs, input logic [3:0] cc);
    return {op, rt, rd, rs, cc, 7'h55};
  endfunction

  function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [15:0] imm);
    return {op, rt, rd, imm};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  task automatic chk_strobes(input string req, input logic [8:0] exp);
    chk(req, "we/fl/rd/wr/cm/j/c/r/imm",
        {23'd0, reg_we, flag_we, mem_rd, mem_wr, cmov, jump, call, ret, use_imm}, {23'd0, exp});
  endtask

  task automatic t_reset_word;
    apply(32'd0);
    chk("R12", "dst zero word", {27'd0, dst_idx}, 32'd0);
    chk_strobes("R12", 9'b010000000);
    chk("R2", "imm zero", imm_ext, 32'd0);
  endtask

  task automatic t_fields;
    apply(rw(6'b000001, 5'd7, 5'd9, 5'd21, 4'b1101));
    chk("R1", "rs", {27'd0, rs_idx}, 32'd21);
    chk("R1", "rt", {27'd0, rt_idx}, 32'd7);
    chk("R1", "rd", {27'd0, rd_idx}, 32'd9);
    chk("R1", "cond", {28'd0, cond}, 32'd13);
    chk("R3", "sub", {28'd0, alu_op}, 32'd1);
    chk_strobes("R5", 9'b110000000);
    chk("R2", "imm rfmt", imm_ext, 32'd0);
  endtask

  task automatic t_arith_logic;
    for (int k = 0; k < 4; k++) begin
      apply(iw({4'b1000, k[1:0]}, 5'd3, 5'd4, 16'h8001));
      chk("R3", "iarith op", {28'd0, alu_op}, k);
      chk("R6", "sext", imm_ext, 32'hFFFF8001);
      chk_strobes("R2", 9'b110000001);
    end
    for (int k = 0; k < 6; k++) begin
      apply(rw({3'b001, k[2:0]}, 5'd1, 5'd2, 5'd3, 4'd0));
      chk("R3", "logic op", {28'd0, alu_op}, 8 + k);
      apply(iw({3'b101, k[2:0]}, 5'd1, 5'd2, 16'hF00F));
      chk("R6", "zext logic", imm_ext, 32'h0000F00F);
      chk_strobes("R5", 9'b110000001);
    end
  endtask

  task automatic t_insert;
    apply(rw(6'b000100, 5'd2, 5'd5, 5'd2, 4'b1001));
    chk("R4", "insl", {28'd0, alu_op}, 32'd4);
    chk("R1", "ins cond", {28'd0, cond}, 32'd9);
    chk_strobes("R5", 9'b110000000);
    apply(rw(6'b000110, 5'd0, 5'd5, 5'd6, 4'b1000));
    chk("R4", "insh", {28'd0, alu_op}, 32'd5);
    apply(iw(6'b110100, 5'd8, 5'd8, 16'h9ABC));
    chk("R4", "insi", {28'd0, alu_op}, 32'd6);
    chk("R6", "insi zext", imm_ext, 32'h00009ABC);
    chk_strobes("R5", 9'b100000001);
    apply(iw(6'b110101, 5'd8, 5'd8, 16'h1234));
    chk("R4", "insin", {28'd0, alu_op}, 32'd7);
  endtask

  task automatic t_mem_move;
    apply(rw(6'b010000, 5'd11, 5'd12, 5'd0, 4'd0));
    chk_strobes("R7", 9'b101000000);
    chk("R7", "ld dst", {27'd0, dst_idx}, 32'd12);
    apply(iw(6'b110010, 5'd13, 5'd0, 16'hFFF0));
    chk_strobes("R7", 9'b000100001);
    chk("R6", "sti zext", imm_ext, 32'h0000FFF0);
    apply(iw(6'b110000, 5'd0, 5'd3, 16'h0040));
    chk_strobes("R7", 9'b101000001);
    apply(rw(6'b010100, 5'd4, 5'd5, 5'd6, 4'b0110));
    chk_strobes("R8", 9'b100010000);
    chk("R8", "cmov alu", {28'd0, alu_op}, 32'd14);
    chk("R8", "cmov cond", {28'd0, cond}, 32'd6);
  endtask

  task automatic t_control;
    apply(rw(6'b011100, 5'b01000, 5'd0, 5'd17, 4'd0));
    chk_strobes("R9", 9'b000001000);
    chk("R9", "jmp always", {28'd0, cond}, 32'd8);
    chk("R9", "jmp rt", {27'd0, rt_idx}, 32'd0);
    apply(iw(6'b111100, 5'b01110, 5'd0, 16'hFFFC));
    chk_strobes("R9", 9'b000001001);
    chk("R9", "jcc cond", {28'd0, cond}, 32'd14);
    chk("R6", "jmp sext", imm_ext, 32'hFFFFFFFC);
    apply(iw(6'b111110, 5'd31, 5'd0, 16'h0100));
    chk_strobes("R10", 9'b000100101);
    chk("R10", "call sp", {27'd0, rt_idx}, 32'd31);
    apply(rw(6'b011110, 5'd31, 5'd0, 5'd9, 4'd0));
    chk_strobes("R10", 9'b000100100);
    apply(iw(6'b111000, 5'd31, 5'd31, 16'h0008));
    chk_strobes("R11", 9'b101000011);
    chk("R11", "ret dst", {27'd0, dst_idx}, 32'd31);
    chk("R11", "ret alu", {28'd0, alu_op}, 32'd0);
    chk("R11", "ret imm", imm_ext, 32'd8);
  endtask

  task automatic t_zero_dst;
    apply(rw(6'b000001, 5'd3, 5'd0, 5'd4, 4'd0));
    chk_strobes("R12", 9'b010000000);
    chk("R12", "dst", {27'd0, dst_idx}, 32'd0);
  endtask

  task automatic t_undefined;
    logic [5:0] bad [6] = '{6'b000101, 6'b000111, 6'b001110, 6'b010001, 6'b111111, 6'b110110};
    for (int k = 0; k < 6; k++) begin
      apply(iw(bad[k], 5'd5, 5'd6, 16'h7777));
      chk_strobes("R13", 9'b000000000);
      chk("R13", "alu", {28'd0, alu_op}, 32'd14);
    end
  endtask

  initial begin
    fork
      begin
        instr = 32'd0;
        t_reset_word();
        t_fields();
        t_arith_logic();
        t_insert();
        t_mem_move();
        t_control();
        t_zero_dst();
        t_undefined();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_vec++;
          n_bad++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule